// File: doc/BRIEF.md
# Dual-Class Interrupt Masking Controller

This block collects 64 level-sensitive interrupt request lines and turns them into two active-low requests for a processor: a normal-class request and a fast-class request. Each source has three software-held control bits: a force bit that raises the source even when its line is low, an enable bit that masks it, and a class bit that sends it to the fast output (1) or the normal output (0). The per-source state is grouped into two 32-bit words, a low word for sources 0 to 31 and a high word for sources 32 to 63.

Software reaches the block through a simple 32-bit register bus. Every access must carry a supervisor qualifier and all four byte enables. Reads return data one cycle after the access. The live source status and the two pending sets can be read but not written. Priority resolution and vector generation happen in a separate block that reads the pending sets. The processor does its own masking of the two outputs.

Register addresses are word indices: address = 2 * group + word, where word 0 is the low half and word 1 the high half. The groups are 0 enable, 1 class, 2 force, 3 source status (read-only), 4 normal pending (read-only) and 5 fast pending (read-only). Addresses 12 to 15 are unmapped.

Top module: `irq_mask_ctrl`

## Requirements
- R1: The source status bit of source n (group 3) equals request line n OR force bit n (group 2), for both halves.
- R2: A source whose enable bit (group 0) is 0 appears in neither pending set and cannot pull either output low.
- R3: Normal pending (group 4) equals source AND enable AND NOT class, and fast pending (group 5) equals source AND enable AND class. Class bit 1 means fast.
- R4: `irq_norm_n` is low exactly when some normal pending bit is set, and `irq_fast_n` is low exactly when some fast pending bit is set. Both change in the cycle after a register write takes effect.
- R5: An access with `bus_super` low changes no register and reads as zero. It raises `bus_err` for exactly the one cycle after the access.
- R6: An access whose byte enables are not all ones is ignored: a write changes nothing, and a read returns zero without an error.
- R7: Writes to the source status and pending registers (groups 3 to 5) are dropped. Later reads still show the computed values.
- R8: After reset, all enable, class and force bits are 0 and both outputs are high.
- R9: The source status is not latched. When a line falls and its force bit is 0, the source clears and the outputs update with no clock edge in between.
- R10: `bus_rdata` is registered. It holds the read value in the cycle after a valid read, and it is zero after any write, any idle cycle or any read of an unmapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address (2 * group + half) |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_super | input | 1 | Supervisor qualifier |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the access |
| bus_err | output | 1 | One-cycle pulse after a non-supervisor access |
| req_lines | input | 64 | Level-sensitive request lines |
| irq_norm_n | output | 1 | Active-low normal-class request |
| irq_fast_n | output | 1 | Active-low fast-class request |

## Verification
Results fall due at two different times. Register writes change the outputs after the capturing edge, so those outputs are checked at the next falling edge. Read data and `bus_err` appear one edge after the access, so the driver queues the expected word when that edge occurs and the monitor compares it at the following falling edge. In the cycle after that, the bench checks that both `bus_rdata` and `bus_err` have returned to zero. Changes on the request lines must reach the outputs with no clock edge in between, so the bench checks them 1 ns after driving the lines, before any rising edge.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
    localparam int DW      = 32;
    localparam int NSRC    = 64;
    localparam int HALVES  = NSRC / DW;
    localparam int HSEL_W  = (HALVES > 1) ? $clog2(HALVES) : 1;
    localparam int ADDR_W  = 4;
    localparam int KIND_W  = ADDR_W - HSEL_W;
    localparam int BE_W    = DW / 8;

    typedef enum logic [KIND_W-1:0] {
        K_EN  = 3'd0,
        K_CLS = 3'd1,
        K_FRC = 3'd2,
        K_RAW = 3'd3,
        K_NPD = 3'd4,
        K_FPD = 3'd5
    } kind_e;

    typedef logic [HALVES-1:0][DW-1:0] bank_t;

    typedef struct packed {
        bank_t en;
        bank_t cls;
        bank_t frc;
    } cfg_t;

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          err;
    } rsp_t;

    function automatic kind_e addr_kind(input logic [ADDR_W-1:0] a);
        return kind_e'(a[ADDR_W-1:HSEL_W]);
    endfunction

    function automatic logic [HSEL_W-1:0] addr_half(input logic [ADDR_W-1:0] a);
        return a[HSEL_W-1:0];
    endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_mask_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic              bus_super,
    input  logic [DW-1:0]     bus_wdata,
    output cfg_t              cfg_q
);
    cfg_t  cfg_d;
    logic  wr_ok;
    kind_e kind;
    logic [HSEL_W-1:0] half;

    assign wr_ok = bus_sel && bus_wr && bus_super && (bus_be == '1);
    assign kind  = addr_kind(bus_addr);
    assign half  = addr_half(bus_addr);

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ok) begin
            case (kind)
                K_EN:    cfg_d.en[half]  = bus_wdata;
                K_CLS:   cfg_d.cls[half] = bus_wdata;
                K_FRC:   cfg_d.frc[half] = bus_wdata;
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    p_nosuper_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_super) |=> (cfg_q == $past(cfg_q)));

    p_partial_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (bus_be != '1)) |=> (cfg_q == $past(cfg_q)));

    p_ro_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (bus_addr[ADDR_W-1:HSEL_W] >= KIND_W'(3))) |=> (cfg_q == $past(cfg_q)));

    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (cfg_q == '0));
endmodule

// File: rtl/irq_pend_logic.sv
module irq_pend_logic
    import irq_mask_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  cfg_t            cfg_q,
    input  logic [NSRC-1:0] req_lines,
    output bank_t           src,
    output bank_t           npd,
    output bank_t           fpd,
    output logic            irq_norm_n,
    output logic            irq_fast_n
);
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign src[h] = req_lines[h*DW +: DW] | cfg_q.frc[h];
        assign npd[h] = src[h] & cfg_q.en[h] & ~cfg_q.cls[h];
        assign fpd[h] = src[h] & cfg_q.en[h] &  cfg_q.cls[h];
    end

    assign irq_norm_n = ~(|npd);
    assign irq_fast_n = ~(|fpd);

    p_class_disjoint_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((npd & fpd) == '0));

    p_norm_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_norm_n |-> (|cfg_q.en));

    p_fast_needs_cls_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_fast_n |-> (|(cfg_q.en & cfg_q.cls)));

    p_src_covers_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((src & bank_t'(req_lines)) == bank_t'(req_lines)));
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
    import irq_mask_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic              bus_super,
    input  cfg_t              cfg_q,
    input  bank_t             src,
    input  bank_t             npd,
    input  bank_t             fpd,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_err
);
    rsp_t  rsp_d, rsp_q;
    logic  rd_ok;
    kind_e kind;
    logic [HSEL_W-1:0] half;
    logic [DW-1:0]     sel_word;

    assign rd_ok = bus_sel && !bus_wr && bus_super && (bus_be == '1);
    assign kind  = addr_kind(bus_addr);
    assign half  = addr_half(bus_addr);

    always_comb begin
        case (kind)
            K_EN:    sel_word = cfg_q.en[half];
            K_CLS:   sel_word = cfg_q.cls[half];
            K_FRC:   sel_word = cfg_q.frc[half];
            K_RAW:   sel_word = src[half];
            K_NPD:   sel_word = npd[half];
            K_FPD:   sel_word = fpd[half];
            default: sel_word = '0;
        endcase
        rsp_d.rdata = rd_ok ? sel_word : '0;
        rsp_d.err   = bus_sel && !bus_super;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign bus_rdata = rsp_q.rdata;
    assign bus_err   = rsp_q.err;

    p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel && !bus_super));

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> (bus_rdata == '0 && !bus_err));

    p_partial_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_super && (bus_be != '1)) |=> (bus_rdata == '0 && !bus_err));
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irq_mask_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic              bus_super,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_err,
    input  logic [NSRC-1:0]   req_lines,
    output logic              irq_norm_n,
    output logic              irq_fast_n
);
    cfg_t  cfg_q;
    bank_t src, npd, fpd;

    irq_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_super (bus_super),
        .bus_wdata (bus_wdata),
        .cfg_q     (cfg_q)
    );

    irq_pend_logic u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_q      (cfg_q),
        .req_lines  (req_lines),
        .src        (src),
        .npd        (npd),
        .fpd        (fpd),
        .irq_norm_n (irq_norm_n),
        .irq_fast_n (irq_fast_n)
    );

    irq_rd_mux u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_super (bus_super),
        .cfg_q     (cfg_q),
        .src       (src),
        .npd       (npd),
        .fpd       (fpd),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );
endmodule

// File: tb/irq_mask_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_mask_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_super = 1'b0;
    logic [3:0]  bus_addr = '0, bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [63:0] req_lines = '0;
    logic        irq_norm_n, irq_fast_n;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    logic [63:0] m_en = '0, m_cls = '0, m_frc = '0;

    logic [31:0] q_d[$];
    logic        q_e[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    irq_mask_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_super(bus_super),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .req_lines(req_lines), .irq_norm_n(irq_norm_n), .irq_fast_n(irq_fast_n)
    );

    function automatic logic [31:0] word_of(input logic [63:0] v, input logic h);
        return h ? v[63:32] : v[31:0];
    endfunction

    function automatic logic [31:0] model_rd(input logic [3:0] a);
        logic [63:0] raw;
        raw = req_lines | m_frc;
        case (a[3:1])
            3'd0: return word_of(m_en, a[0]);
            3'd1: return word_of(m_cls, a[0]);
            3'd2: return word_of(m_frc, a[0]);
            3'd3: return word_of(raw, a[0]);
            3'd4: return word_of(raw & m_en & ~m_cls, a[0]);
            3'd5: return word_of(raw & m_en & m_cls, a[0]);
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(input string tag);
        logic [63:0] raw;
        logic en_n, ef_n;
        raw  = req_lines | m_frc;
        en_n = ~|(raw & m_en & ~m_cls);
        ef_n = ~|(raw & m_en & m_cls);
        check({tag, " irq_norm_n"}, {31'b0, irq_norm_n}, {31'b0, en_n});
        check({tag, " irq_fast_n"}, {31'b0, irq_fast_n}, {31'b0, ef_n});
    endtask

    // Driver: one access, expected response queued at the capturing edge.
    task automatic acc(input logic wr, input logic [3:0] a, input logic [31:0] wd,
                       input logic [3:0] be, input logic sup, input string tag);
        logic [31:0] exp_d;
        logic        ok;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        bus_be = be; bus_super = sup;
        ok = sup && (be == 4'hF);
        exp_d = (!wr && ok) ? model_rd(a) : 32'h0;
        @(posedge clk);
        q_d.push_back(exp_d); q_e.push_back(!sup); q_tag.push_back(tag);
        if (wr && ok) begin
            case (a[3:1])
                3'd0: if (a[0]) m_en[63:32]  = wd; else m_en[31:0]  = wd;
                3'd1: if (a[0]) m_cls[63:32] = wd; else m_cls[31:0] = wd;
                3'd2: if (a[0]) m_frc[63:32] = wd; else m_frc[31:0] = wd;
                default: ;
            endcase
        end
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'h0; bus_super = 1'b0;
        @(negedge clk);
        // R10 and R5: response is zero and the error pulse is gone one cycle later
        check("R10 idle rdata", bus_rdata, 32'h0);
        check("R5 err one cycle", {31'b0, bus_err}, 32'h0);
    endtask

    // Monitor: compares queued responses one cycle after the access.
    always @(negedge clk) begin
        if (q_d.size() > 0) begin
            check({q_tag[0], " rdata"}, bus_rdata, q_d[0]);
            check({q_tag[0], " err"}, {31'b0, bus_err}, {31'b0, q_e[0]});
            void'(q_d.pop_front()); void'(q_e.pop_front()); void'(q_tag.pop_front());
        end
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_irq("R8");
        for (int a = 0; a < 6; a++) acc(1'b0, 4'(a), 32'h0, 4'hF, 1'b1, "R8 reset read");

        req_lines = 64'h8000_0001_0000_0010;
        @(negedge clk);
        chk_irq("R2 nothing enabled");
        acc(1'b0, 4'd6, 32'h0, 4'hF, 1'b1, "R1 raw lo");
        acc(1'b0, 4'd7, 32'h0, 4'hF, 1'b1, "R1 raw hi");
        acc(1'b0, 4'd8, 32'h0, 4'hF, 1'b1, "R2 npd lo masked");

        acc(1'b1, 4'd0, 32'h0000_0010, 4'hF, 1'b1, "R4 en lo");
        chk_irq("R4 normal asserted");
        acc(1'b0, 4'd8, 32'h0, 4'hF, 1'b1, "R3 npd lo");

        acc(1'b1, 4'd2, 32'h0000_0010, 4'hF, 1'b1, "R3 cls lo");
        chk_irq("R3 moved to fast");
        acc(1'b0, 4'd10, 32'h0, 4'hF, 1'b1, "R3 fpd lo");
        acc(1'b0, 4'd8, 32'h0, 4'hF, 1'b1, "R3 npd lo empty");

        acc(1'b1, 4'd1, 32'h8000_0001, 4'hF, 1'b1, "R4 en hi");
        chk_irq("R4 both asserted");
        acc(1'b0, 4'd9, 32'h0, 4'hF, 1'b1, "R3 npd hi");

        @(negedge clk);
        req_lines = 64'h0;
        #1;
        chk_irq("R9 no latch");
        acc(1'b0, 4'd6, 32'h0, 4'hF, 1'b1, "R9 raw lo clear");

        acc(1'b1, 4'd5, 32'h0000_0004, 4'hF, 1'b1, "R1 frc hi");
        chk_irq("R2 forced not enabled");
        acc(1'b0, 4'd7, 32'h0, 4'hF, 1'b1, "R1 raw hi forced");
        acc(1'b1, 4'd1, 32'h0000_0004, 4'hF, 1'b1, "R1 en forced");
        chk_irq("R1 force drives normal");

        acc(1'b1, 4'd1, 32'h0, 4'hF, 1'b0, "R5 user write");
        chk_irq("R5 user write dropped");
        acc(1'b0, 4'd1, 32'h0, 4'hF, 1'b0, "R5 user read");
        acc(1'b0, 4'd1, 32'h0, 4'hF, 1'b1, "R5 en hi kept");

        acc(1'b1, 4'd1, 32'h0, 4'h3, 1'b1, "R6 partial write");
        acc(1'b0, 4'd1, 32'h0, 4'hF, 1'b1, "R6 en hi kept");
        acc(1'b0, 4'd1, 32'h0, 4'h1, 1'b1, "R6 partial read");
        chk_irq("R6 outputs kept");

        req_lines = 64'h0000_0000_0000_0300;
        acc(1'b1, 4'd6, 32'hFFFF_FFFF, 4'hF, 1'b1, "R7 raw write");
        acc(1'b1, 4'd9, 32'hFFFF_FFFF, 4'hF, 1'b1, "R7 npd write");
        acc(1'b1, 4'd10, 32'hFFFF_FFFF, 4'hF, 1'b1, "R7 fpd write");
        acc(1'b0, 4'd6, 32'h0, 4'hF, 1'b1, "R7 raw lo");
        acc(1'b0, 4'd9, 32'h0, 4'hF, 1'b1, "R7 npd hi");
        acc(1'b0, 4'd10, 32'h0, 4'hF, 1'b1, "R7 fpd lo");
        chk_irq("R7 outputs");

        acc(1'b0, 4'd12, 32'h0, 4'hF, 1'b1, "R10 unmapped");
        acc(1'b0, 4'd15, 32'h0, 4'hF, 1'b1, "R10 unmapped top");

        repeat (2) @(negedge clk);
        done = 1;
        finish_run();
    end
endmodule